// File: doc/BRIEF.md
# Field Half-Line Counter with 50/60 Hz Standard Detection

This block tracks the vertical position of a television field by counting half-line strobes. It runs on a 13.5 MHz clock and receives two one-cycle strobes: a half-line tick, which arrives twice per line, and an already cleaned vertical sync. From the number of half-lines that separate two vertical syncs it decides whether the incoming signal follows the 625-line (50 Hz) or the 525-line (60 Hz) standard. It reports that decision on an active-low flag.

From its field position it drives a vertical blanking window. The span of that window depends on the detected standard. A delayed vertical output pulse of fixed width is also produced, registered on the clock. When vertical syncs stop arriving, the position counter wraps by itself at the nominal field length of the current standard. Vertical timing therefore continues without input.

All inputs and outputs are plain control signals with no handshake. The strobes are sampled on every rising clock edge, and the outputs change only on clock edges.

Top module: `vfield_timer`

## Requirements
- R1: While reset is held and immediately after it is released, flag50_n is 0, vout is 0 and vblank is 1.
- R2: The field position advances by one on each clock edge that samples half_tick high. A sampled vsync_in returns it to 0, and vsync_in wins over a half_tick in the same cycle, so that tick is neither counted nor measured.
- R3: Without vsync_in, the position wraps to 0 after 625 half-lines in 50 Hz mode or 525 half-lines in 60 Hz mode. The wrap counts as a field start for vout and leaves the detected standard unchanged.
- R4: The measured length is the number of half_tick strobes between two consecutive vsync_in strobes. It saturates at 1023 and is not cleared by a free-running wrap. On the closing vsync_in, a length of 575 or more selects 50 Hz (flag50_n = 0), and 574 or less selects 60 Hz (flag50_n = 1). The new value is visible after that edge.
- R5: After reset the standard is 50 Hz. The first vsync_in after reset only opens a measurement and does not change the flag.
- R6: A field start (vsync_in or wrap) sampled on edge E sets vout to 0 after E. vout is then 1 after edges E+DLY through E+DLY+LEN-1 and 0 afterwards. A new field start restarts this sequence. The defaults are DLY = 216 and LEN = 4320 clocks, which is 16 µs and 320 µs at 13.5 MHz.
- R7: In 50 Hz mode vblank is 1 when the position is below 45 or at 620 and above. That covers 22.5 lines after and 2.5 lines before the field start.
- R8: In 60 Hz mode vblank is 1 when the position is below 34 or at 519 and above. That covers 17 lines after and 3 lines before the field start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.5 MHz clock |
| rst_n | input | 1 | asynchronous reset, active low |
| half_tick | input | 1 | one-cycle strobe per half-line |
| vsync_in | input | 1 | one-cycle cleaned vertical sync strobe |
| flag50_n | output | 1 | 0 for 50 Hz standard, 1 for 60 Hz |
| vout | output | 1 | registered vertical output pulse |
| vblank | output | 1 | vertical blanking window |

## Verification
The bench sweeps the closing field length across 570 to 580 half-lines. This shows whether the 574/575 decision boundary is placed correctly. It adds fields of 300 and 1100 half-lines, which separate plain classification from saturation of the measurement and from any interference by the free-running wrap. Long runs without vertical sync in both modes expose a wrong wrap length, and they check every blanking position on both sides of the field start. A vertical sync that coincides with a tick checks the precedence rule, and a sync sent twice in close succession checks that the output pulse restarts.

// File: rtl/vft_pkg.sv
package vft_pkg;
  typedef enum logic {
    STD_60 = 1'b0,
    STD_50 = 1'b1
  } fstd_e;
endpackage

// File: rtl/vft_halfline_cnt.sv
module vft_halfline_cnt
  import vft_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int WRAP50 = 625,
  parameter int WRAP60 = 525
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             vs,
  input  fstd_e            std,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] meas,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] LAST50   = CNT_W'(WRAP50 - 1);
  localparam logic [CNT_W-1:0] LAST60   = CNT_W'(WRAP60 - 1);
  localparam logic [CNT_W-1:0] MEAS_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] last_sel;
  assign last_sel = (std == STD_50) ? LAST50 : LAST60;
  assign wrap_evt = tick && !vs && (pos == last_sel);

  // position counter: wraps at the nominal field length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (vs) begin
      pos <= '0;
    end else if (tick) begin
      pos <= (pos == last_sel) ? '0 : pos + 1'b1;
    end
  end

  // measurement counter: cleared only by vertical sync, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas <= '0;
    end else if (vs) begin
      meas <= '0;
    end else if (tick && (meas != MEAS_MAX)) begin
      meas <= meas + 1'b1;
    end
  end

  p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= last_sel);
  p_vs_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vs |=> (pos == '0) && (meas == '0));
  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !vs && (pos != last_sel)) |=> (pos == $past(pos) + 1'b1));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !vs) |=> $stable(pos) && $stable(meas));
endmodule

// File: rtl/vft_std_detect.sv
module vft_std_detect
  import vft_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int THRESH = 575
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vs,
  input  logic [CNT_W-1:0] meas,
  output fstd_e            std,
  output logic             armed
);
  localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std   <= STD_50;
      armed <= 1'b0;
    end else if (vs) begin
      armed <= 1'b1;
      if (armed) std <= (meas >= THR) ? STD_50 : STD_60;
    end
  end

  p_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (std == STD_50));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !vs |=> $stable(std));
  p_long_is50_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vs && armed && (meas >= THR)) |=> (std == STD_50));
endmodule

// File: rtl/vft_vpulse.sv
module vft_vpulse #(
  parameter int DLY = 216,
  parameter int LEN = 4320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic vout
);
  localparam int SPAN = DLY + LEN;
  localparam int TW   = $clog2(SPAN + 1);
  localparam logic [TW-1:0] ON_AT  = TW'(DLY - 1);
  localparam logic [TW-1:0] END_AT = TW'(SPAN - 1);

  logic [TW-1:0] tmr;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr  <= '0;
      run  <= 1'b0;
      vout <= 1'b0;
    end else if (trig) begin
      tmr  <= '0;
      run  <= 1'b1;
      vout <= 1'b0;
    end else begin
      vout <= run && (tmr >= ON_AT) && (tmr < END_AT);
      if (run) begin
        if (tmr == END_AT) run <= 1'b0;
        else               tmr <= tmr + 1'b1;
      end
    end
  end

  p_trig_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !vout);
  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !trig) |=> !vout);
endmodule

// File: rtl/vft_blank.sv
module vft_blank
  import vft_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int WRAP50 = 625,
  parameter int WRAP60 = 525,
  parameter int AFT50  = 45,
  parameter int BEF50  = 5,
  parameter int AFT60  = 34,
  parameter int BEF60  = 6
) (
  input  logic [CNT_W-1:0] pos,
  input  fstd_e            std,
  output logic             vblank
);
  localparam logic [CNT_W-1:0] LO50 = CNT_W'(AFT50);
  localparam logic [CNT_W-1:0] HI50 = CNT_W'(WRAP50 - BEF50);
  localparam logic [CNT_W-1:0] LO60 = CNT_W'(AFT60);
  localparam logic [CNT_W-1:0] HI60 = CNT_W'(WRAP60 - BEF60);

  always_comb begin
    if (std == STD_50) vblank = (pos < LO50) || (pos >= HI50);
    else               vblank = (pos < LO60) || (pos >= HI60);
  end
endmodule

// File: rtl/vfield_timer.sv
module vfield_timer
  import vft_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int WRAP50 = 625,
  parameter int WRAP60 = 525,
  parameter int THRESH = 575,
  parameter int VDLY   = 216,
  parameter int VLEN   = 4320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_tick,
  input  logic vsync_in,
  output logic flag50_n,
  output logic vout,
  output logic vblank
);
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] meas;
  logic             wrap_evt;
  logic             armed;
  fstd_e            std;

  vft_halfline_cnt #(.CNT_W(CNT_W), .WRAP50(WRAP50), .WRAP60(WRAP60)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(half_tick), .vs(vsync_in), .std(std),
    .pos(pos), .meas(meas), .wrap_evt(wrap_evt));

  vft_std_detect #(.CNT_W(CNT_W), .THRESH(THRESH)) u_det (
    .clk(clk), .rst_n(rst_n), .vs(vsync_in), .meas(meas),
    .std(std), .armed(armed));

  vft_vpulse #(.DLY(VDLY), .LEN(VLEN)) u_vp (
    .clk(clk), .rst_n(rst_n), .trig(vsync_in || wrap_evt), .vout(vout));

  vft_blank #(.CNT_W(CNT_W), .WRAP50(WRAP50), .WRAP60(WRAP60)) u_blk (
    .pos(pos), .std(std), .vblank(vblank));

  assign flag50_n = (std == STD_60);

  p_flag_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_in && !armed) |=> !flag50_n);
endmodule

// File: tb/test_vfield_timer.sv
module test_vfield_timer;
  localparam int TB_DLY = 5;
  localparam int TB_LEN = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_tick = 1'b0;
  logic vsync_in = 1'b0;
  logic flag50_n, vout, vblank;

  int total = 0;
  int bad = 0;
  bit chk_on = 0;

  always #10 clk = ~clk;

  vfield_timer #(.VDLY(TB_DLY), .VLEN(TB_LEN)) i_vfield_timer (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .vsync_in(vsync_in),
    .flag50_n(flag50_n), .vout(vout), .vblank(vblank));

  // bench model, updated on every rising edge from the sampled inputs
  int m_pos, m_meas, m_vt;
  bit m_armed, m_std50;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_meas = 0; m_vt = -1; m_armed = 0; m_std50 = 1;
    end else if (vsync_in) begin
      if (m_armed) m_std50 = (m_meas >= 575);
      m_armed = 1; m_meas = 0; m_pos = 0; m_vt = 0;
    end else begin
      if (m_vt >= 0 && m_vt < 100000) m_vt++;
      if (half_tick) begin
        if (m_meas < 1023) m_meas++;
        if (m_pos == (m_std50 ? 625 : 525) - 1) begin
          m_pos = 0; m_vt = 0;
        end else m_pos++;
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  // continuous comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      chk(vout, (m_vt >= TB_DLY) && (m_vt < TB_DLY + TB_LEN),
          $sformatf("R6 vout vt=%0d", m_vt));
      if (m_std50)
        chk(vblank, (m_pos < 45) || (m_pos >= 620),
            $sformatf("R2 R3 R7 vblank pos=%0d", m_pos));
      else
        chk(vblank, (m_pos < 34) || (m_pos >= 519),
            $sformatf("R2 R3 R8 vblank pos=%0d", m_pos));
      chk(flag50_n, !m_std50, m_armed ? "R4 flag" : "R5 flag");
    end
  end

  task automatic cyc(input logic t, input logic v);
    @(negedge clk);
    half_tick = t; vsync_in = v;
    @(posedge clk);
    #3;
    half_tick = 1'b0; vsync_in = 1'b0;
  endtask

  task automatic tick3();
    cyc(1'b1, 1'b0); cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
  endtask

  task automatic field(input int n, input logic close_tick, input logic exp_flag,
                       input string tag);
    for (int i = 0; i < n; i++) tick3();
    cyc(close_tick, 1'b1);
    chk(flag50_n, exp_flag, $sformatf("%s len=%0d", tag, n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(flag50_n, 1'b0, "R1 flag in reset");
    chk(vout, 1'b0, "R1 vout in reset");
    chk(vblank, 1'b1, "R1 vblank in reset");
    rst_n = 1'b1;
    @(posedge clk); #3;
    chk(flag50_n, 1'b0, "R1 flag after reset");
    chk(vout, 1'b0, "R1 vout after reset");
    chk(vblank, 1'b1, "R1 vblank after reset");
    chk_on = 1;

    // free run in 50 Hz mode: two wraps at 625 (R3)
    for (int i = 0; i < 1300; i++) tick3();
    // first sync only arms (R5): a short field must not switch
    field(300, 1'b0, 1'b0, "R5 first sync");
    field(300, 1'b0, 1'b1, "R4 short field");
    // free run in 60 Hz mode wraps at 525; measurement saturates (R3, R4)
    field(1100, 1'b0, 1'b0, "R4 saturated");
    // boundary sweep around 574/575 (R4)
    for (int n = 570; n <= 580; n++)
      field(n, 1'b0, (n < 575), "R4 sweep");
    field(525, 1'b0, 1'b1, "R4 nominal 60");
    field(625, 1'b0, 1'b0, "R4 nominal 50");
    // closing sync with coincident tick: tick dropped, 574 -> 60 Hz (R2)
    field(574, 1'b1, 1'b1, "R2 coincident tick");
    // restart of vout while active (R6)
    cyc(1'b0, 1'b1);
    repeat (8) cyc(1'b0, 1'b0);
    chk(vout, 1'b1, "R6 vout high before restart");
    cyc(1'b0, 1'b1);
    chk(vout, 1'b0, "R6 vout low on restart");
    repeat (TB_DLY + TB_LEN + 4) cyc(1'b0, 1'b0);
    chk(vout, 1'b0, "R6 vout ends");

    chk_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule